// File: doc/BRIEF.md
# Prioritized interrupt request arbiter

This block gathers every interrupt source of a small 16-bit processor core and, at each instruction boundary, chooses one request to hand to the core's interrupt sequencer together with its 8-bit type number. The sources are a core reset request, three internal exception strobes, a software-interrupt strobe carrying its own type operand, a non-maskable pin, and a maskable pin whose type comes from outside. The current interrupt-enable and trap flags are also inputs.

Requests are taken only when `boundary_i` is high. On that edge the highest pending request wins, and the block emits a one-cycle `req_o` pulse with `type_o` on the next cycle. Exception, single-step and software requests that lose the arbitration stay pending for later boundaries. The non-maskable pin feeds a latch that is set by a qualified rising edge and is cleared when the latch's own request is granted. The maskable pin is a level. It is looked at only on a boundary and is never stored. Stack pushes, vector fetch and decoding are the sequencer's job.

Top module: `irq_arbiter`

## Requirements
- R1: While `core_reset_i` is high, `reset_o` is 1 and `req_o` is 0 from the next cycle on. All pending requests and the NMI latch are cleared. `reset_o` returns to 0 the cycle after the request drops. After `rst_ni`, both `req_o` and `reset_o` are 0.
- R2: Strobes and levels are sampled only on a clock edge where `boundary_i` is 1. Strobes given at any other cycle have no effect. A grant shows as `req_o`=1 for exactly the one cycle after that edge.
- R3: The sources rank from high to low as follows: divide error, overflow trap, breakpoint, single step, software interrupt, NMI, then INTR. Only the highest-ranked source is granted at each boundary.
- R4: A divide-error, overflow-trap, breakpoint, single-step or software request that loses stays pending. It is granted at a later boundary once nothing ranked above it is present.
- R5: `if_flag_i`=0 blocks INTR only. INTR is granted with `type_o`=`intr_type_i` only when `intr_i`=1 and `if_flag_i`=1 at the boundary, and it is never held pending.
- R6: The NMI latch sets only when `nmi_i` was 0 and then stayed 1 for two consecutive sampled clocks. A one-cycle high pulse is ignored.
- R7: A set NMI latch is granted with `type_o`=2 and clears on that grant. A second qualified edge that arrives while the latch is already set is not counted.
- R8: `into_i` raises `type_o`=4 only if `ovf_flag_i`=1 at the boundary. Otherwise it raises nothing.
- R9: `tf_flag_i`=1 at a boundary raises `type_o`=1.
- R10: `swi_i` raises the type given on `swi_type_i`, with any value from 0 to 255 allowed.
- R11: `div_err_i` raises `type_o`=0. `brk_i` raises `type_o`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| core_reset_i | input | 1 | Core reset request, highest rank |
| div_err_i | input | 1 | Divide-result-too-large strobe |
| into_i | input | 1 | Overflow-trap instruction strobe |
| ovf_flag_i | input | 1 | Current overflow flag |
| brk_i | input | 1 | Breakpoint instruction strobe |
| swi_i | input | 1 | Software interrupt instruction strobe |
| swi_type_i | input | 8 | Software interrupt type operand |
| nmi_i | input | 1 | Non-maskable interrupt pin |
| intr_i | input | 1 | Maskable interrupt pin |
| intr_type_i | input | 8 | Type supplied with INTR |
| if_flag_i | input | 1 | Interrupt-enable flag |
| tf_flag_i | input | 1 | Trap (single-step) flag |
| req_o | output | 1 | One-cycle service request |
| type_o | output | 8 | Type number of the granted request |
| reset_o | output | 1 | Reset indication |

## Verification
Two things can collide in the same cycle. A set NMI latch can be granted on the very edge where a fresh qualified NMI edge arrives, and a core reset can arrive on the same boundary as live exception strobes. The bench forces both on purpose. It queues one NMI and then raises a second edge before the boundary, and it holds reset together with strobes. Random traffic also hits both often, with the NMI pin toggled and reset pulsed at random. The bench's reference model decides each outcome from R1 and R7: the second edge is dropped and the latch ends up clear, and reset wins with no request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int TYPE_W = 8;

  // source index == rank, 0 highest
  localparam int SRC_DIV   = 0;
  localparam int SRC_INTO  = 1;
  localparam int SRC_BRK   = 2;
  localparam int SRC_STEP  = 3;
  localparam int SRC_SWI   = 4;
  localparam int SRC_NMI   = 5;
  localparam int SRC_INTR  = 6;
  localparam int SRC_COUNT = 7;
  localparam int HELD_COUNT = SRC_SWI + 1;  // sources kept pending

  localparam logic [TYPE_W-1:0] T_DIV  = TYPE_W'(0);
  localparam logic [TYPE_W-1:0] T_STEP = TYPE_W'(1);
  localparam logic [TYPE_W-1:0] T_NMI  = TYPE_W'(2);
  localparam logic [TYPE_W-1:0] T_BRK  = TYPE_W'(3);
  localparam logic [TYPE_W-1:0] T_INTO = TYPE_W'(4);
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch #(
  parameter int HIGH_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  input  logic flush_i,
  output logic pend_o
);
  logic [HIGH_CYC-1:0] hist_q;
  logic qual;

  // low, then high for HIGH_CYC samples (current included)
  assign qual = nmi_i & (&hist_q[HIGH_CYC-2:0]) & ~hist_q[HIGH_CYC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      pend_o <= 1'b0;
    end else begin
      hist_q <= {hist_q[HIGH_CYC-2:0], nmi_i};
      if (flush_i)              pend_o <= 1'b0;
      else if (!pend_o && qual) pend_o <= 1'b1;
      else if (clr_i)           pend_o <= 1'b0;
    end
  end

  assert_nmi_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_o) |-> ($past(nmi_i) && $past(hist_q[0])));

  assert_nmi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && clr_i) |=> !pend_o);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 7,
  parameter int TW = 8
) (
  input  logic [N-1:0]         cand_i,
  input  logic [N-1:0][TW-1:0] type_i,
  output logic [N-1:0]         grant_o,
  output logic                 any_o,
  output logic [TW-1:0]        type_o
);
  always_comb begin
    grant_o = '0;
    type_o  = '0;
    any_o   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (cand_i[k] && !any_o) begin
        grant_o[k] = 1'b1;
        type_o     = type_i[k];
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int TW           = TYPE_W,
  parameter int NMI_HIGH_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boundary_i,
  input  logic          core_reset_i,
  input  logic          div_err_i,
  input  logic          into_i,
  input  logic          ovf_flag_i,
  input  logic          brk_i,
  input  logic          swi_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic [TW-1:0] intr_type_i,
  input  logic          if_flag_i,
  input  logic          tf_flag_i,
  output logic          req_o,
  output logic [TW-1:0] type_o,
  output logic          reset_o
);
  logic [HELD_COUNT-1:0]       held_q;
  logic [TW-1:0]               swi_type_q;
  logic [SRC_COUNT-1:0]        cand, grant;
  logic [SRC_COUNT-1:0][TW-1:0] types;
  logic [TW-1:0]               sel_type;
  logic                        any, nmi_pend, nmi_clr;

  assign cand[SRC_DIV]  = held_q[SRC_DIV]  | div_err_i;
  assign cand[SRC_INTO] = held_q[SRC_INTO] | (into_i & ovf_flag_i);
  assign cand[SRC_BRK]  = held_q[SRC_BRK]  | brk_i;
  assign cand[SRC_STEP] = held_q[SRC_STEP] | tf_flag_i;
  assign cand[SRC_SWI]  = held_q[SRC_SWI]  | swi_i;
  assign cand[SRC_NMI]  = nmi_pend;
  assign cand[SRC_INTR] = intr_i & if_flag_i;

  assign types[SRC_DIV]  = TW'(T_DIV);
  assign types[SRC_INTO] = TW'(T_INTO);
  assign types[SRC_BRK]  = TW'(T_BRK);
  assign types[SRC_STEP] = TW'(T_STEP);
  assign types[SRC_SWI]  = swi_i ? swi_type_i : swi_type_q;
  assign types[SRC_NMI]  = TW'(T_NMI);
  assign types[SRC_INTR] = intr_type_i;

  irq_prio_pick #(.N(SRC_COUNT), .TW(TW)) u_pick (
    .cand_i (cand),
    .type_i (types),
    .grant_o(grant),
    .any_o  (any),
    .type_o (sel_type)
  );

  assign nmi_clr = boundary_i & ~core_reset_i & grant[SRC_NMI];

  irq_nmi_latch #(.HIGH_CYC(NMI_HIGH_CYC)) u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (nmi_clr),
    .flush_i(core_reset_i),
    .pend_o (nmi_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q     <= '0;
      swi_type_q <= '0;
      req_o      <= 1'b0;
      type_o     <= '0;
      reset_o    <= 1'b0;
    end else if (core_reset_i) begin
      held_q  <= '0;
      req_o   <= 1'b0;
      reset_o <= 1'b1;
    end else begin
      reset_o <= 1'b0;
      req_o   <= boundary_i & any;
      if (boundary_i) begin
        held_q <= cand[HELD_COUNT-1:0] & ~grant[HELD_COUNT-1:0];
        if (swi_i) swi_type_q <= swi_type_i;
        if (any)   type_o     <= sel_type;
      end
    end
  end

  assert_reset_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_i |=> (reset_o && !req_o));

  assert_req_at_boundary_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(boundary_i));

  assert_single_grant_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_intr_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !if_flag_i && !core_reset_i && cand[SRC_NMI:0] == '0) |=> !req_o);
endmodule

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  logic clk = 0, rst_ni = 0;
  logic boundary, core_reset, div_err, into, ovf, brk, swi, nmi, intr, ifl, tf;
  logic [7:0] swi_type, intr_type;
  logic req; logic [7:0] typ; logic rst_ind;

  always #2 clk = ~clk;  // 250 MHz

  irq_arbiter uut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary), .core_reset_i(core_reset),
    .div_err_i(div_err), .into_i(into), .ovf_flag_i(ovf), .brk_i(brk), .swi_i(swi),
    .swi_type_i(swi_type), .nmi_i(nmi), .intr_i(intr), .intr_type_i(intr_type),
    .if_flag_i(ifl), .tf_flag_i(tf), .req_o(req), .type_o(typ), .reset_o(rst_ind));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit [4:0] m_held; bit [7:0] m_swi_t; bit m_h0, m_h1, m_lat;
  bit e_req, e_rst; bit [7:0] e_type; string e_tag;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string src_tag(int s);
    case (s)
      0: return "R11"; 1: return "R8"; 2: return "R11"; 3: return "R9";
      4: return "R10"; 5: return "R7"; default: return "R5";
    endcase
  endfunction

  // advance model by one clock edge using currently driven inputs
  function automatic void model_step(string tag);
    bit qual; bit [6:0] c; bit [7:0] t [7]; int g;
    qual = nmi && m_h0 && !m_h1;
    e_tag = tag;
    if (core_reset) begin
      e_rst = 1; e_req = 0; m_held = 0; m_lat = 0; e_tag = {tag, "/R1"};
    end else begin
      e_rst = 0; e_req = 0;
      c[0] = m_held[0] | div_err; c[1] = m_held[1] | (into & ovf);
      c[2] = m_held[2] | brk;     c[3] = m_held[3] | tf;
      c[4] = m_held[4] | swi;     c[5] = m_lat; c[6] = intr & ifl;
      t[0] = 0; t[1] = 4; t[2] = 3; t[3] = 1; t[4] = swi ? swi_type : m_swi_t;
      t[5] = 2; t[6] = intr_type;
      g = -1;
      if (boundary) begin
        for (int k = 0; k < 7; k++) if (c[k] && g < 0) g = k;
        if (g >= 0) begin
          e_req = 1; e_type = t[g]; e_tag = {tag, "/R3/", src_tag(g)};
        end else e_tag = {tag, "/R2"};
        m_held = c[4:0];
        if (g >= 0 && g < 5) m_held[g] = 0;
        if (swi) m_swi_t = swi_type;
      end else e_tag = {tag, "/R2"};
      if (!m_lat && qual) m_lat = 1;
      else if (g == 5) m_lat = 0;
    end
    m_h1 = m_h0; m_h0 = nmi;
  endfunction

  task automatic check_out();
    chk({e_tag, " reset_o"}, {7'd0, rst_ind}, {7'd0, e_rst});
    chk({e_tag, " req_o"}, {7'd0, req}, {7'd0, e_req});
    if (e_req) chk({e_tag, " type_o"}, typ, e_type);
  endtask

  // inputs already set by caller; check previous result, then clock
  task automatic tick(string tag);
    model_step(tag);
    @(negedge clk);
    check_out();
  endtask

  task automatic clr();
    boundary = 0; core_reset = 0; div_err = 0; into = 0; ovf = 0; brk = 0; swi = 0;
    swi_type = 0; intr = 0; intr_type = 0; tf = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr(); nmi = 0; ifl = 1;
    m_held = 0; m_swi_t = 0; m_h0 = 0; m_h1 = 0; m_lat = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset state req_o", {7'd0, req}, 8'd0);
    chk("R1 reset state reset_o", {7'd0, rst_ind}, 8'd0);
    rst_ni = 1;
    @(negedge clk);

    // R1: reset request beats live strobes
    core_reset = 1; boundary = 1; div_err = 1; swi = 1; swi_type = 8'h77;
    tick("R1"); tick("R1");
    clr(); tick("R1 release"); tick("R1 idle");

    // R3/R4: everything at one boundary, then drain
    nmi = 1; tick("R6 arm"); tick("R6 arm");
    boundary = 1; div_err = 1; into = 1; ovf = 1; brk = 1; tf = 1;
    swi = 1; swi_type = 8'hA5; intr = 1; intr_type = 8'h5C;
    tick("R3 all");
    div_err = 0; into = 0; ovf = 0; brk = 0; tf = 0; swi = 0; swi_type = 0;
    repeat (7) tick("R4 drain");
    clr(); nmi = 0; tick("R4 done");

    // R2: strobes away from boundary are ignored
    div_err = 1; brk = 1; swi = 1; swi_type = 8'h11; tf = 1; into = 1; ovf = 1;
    tick("R2 off"); clr(); boundary = 1; tick("R2 empty"); clr(); tick("R2");

    // R5: IF masks INTR only
    boundary = 1; intr = 1; intr_type = 8'h40; ifl = 0; tick("R5 masked");
    swi = 1; swi_type = 8'hFF; tick("R5 swi unmasked");
    clr(); ifl = 1; tick("R5");

    // R6: single-cycle NMI pulse ignored
    nmi = 1; tick("R6 pulse"); nmi = 0; tick("R6");
    boundary = 1; tick("R6 check"); clr(); tick("R6");

    // R7: second edge while latched not counted; edge on grant cycle dropped
    nmi = 1; tick("R7"); tick("R7"); nmi = 0; tick("R7");
    nmi = 1; tick("R7"); boundary = 1; tick("R7 grant+edge");
    tick("R7 again"); clr(); nmi = 0; tick("R7");

    // R8: INTO without overflow
    boundary = 1; into = 1; ovf = 0; tick("R8 no ovf");
    ovf = 1; tick("R8 ovf"); clr(); tick("R8");

    // R10 boundary values
    boundary = 1; swi = 1; swi_type = 8'h00; tick("R10 zero");
    swi_type = 8'hFF; tick("R10 max"); clr(); tick("R10");

    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      boundary   = ($urandom % 2) == 0;
      core_reset = ($urandom % 50) == 0;
      div_err    = ($urandom % 12) == 0;
      into       = ($urandom % 10) == 0;
      ovf        = ($urandom % 2) == 0;
      brk        = ($urandom % 12) == 0;
      swi        = ($urandom % 8) == 0;
      swi_type   = 8'($urandom);
      if (($urandom % 4) == 0) nmi = ~nmi;
      intr       = ($urandom % 3) == 0;
      intr_type  = 8'($urandom);
      ifl        = ($urandom % 4) != 0;
      tf         = ($urandom % 10) == 0;
      tick("RND");
    end
    clr(); tick("RND end");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule